// File: doc/BRIEF.md
# In-Order Load Queue with Sub-Block Merging

This block holds issued loads between the pipeline and the request port of a second-level cache. When a load arrives, its 16-byte sub-block is compared with every entry already waiting. If an older entry owns a fetch for the same sub-block, the new load joins that fetch and makes no request of its own. All other loads each place one request for their 16-byte chunk. Requests leave oldest first. A rate input selects whether the port may take a request on every cycle or only on alternate cycles.

Fills come back on a tagged 16-byte bus and may arrive in any order. A fill completes the entry that owns it and every entry merged onto that entry. Loads retire one per cycle and strictly in program order. A retiring load returns the 8-byte half of its line that address bit 3 selects. A merged load that sits behind an unfinished older miss waits for that miss.

Top module: `load_merge_buf`

## Requirements
- R1: The queue holds `DEPTH` loads (default 8). `enq_ready` is low exactly when all entries are in use. While it is low, `enq_valid` has no effect, and out of reset `enq_ready` is high with `req_valid` and `ret_valid` low.
- R2: Two addresses are in the same sub-block when they agree in every bit above bit 3. Bits 3..0 play no part in the comparison.
- R3: A load with no older owner in its sub-block becomes an owner. It issues exactly one request, with `req_idx` equal to its entry number and `req_addr` equal to its address with bits 3..0 cleared.
- R4: A load whose sub-block is owned by a waiting older entry issues no request. It completes on its owner's fill, or at once if that fill has already arrived. While any request for a sub-block is unfilled, no second request for that sub-block appears.
- R5: Loads retire one per cycle, in the order they entered. `ret_addr` is the load address. `ret_data` is `fill_data[127:64]` when address bit 3 is 1 and `fill_data[63:0]` when it is 0.
- R6: When `half_rate` is 1, `req_valid` is never high in two consecutive cycles.
- R7: When `half_rate` is 0, requests may be issued on consecutive cycles. Each owner is requested once, and owners are requested in program order.
- R8: If the only matching owner retires in the same cycle a new load enters, the new load becomes an owner and issues its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_rate | input | 1 | 1: at most one request every other cycle |
| enq_valid | input | 1 | New load present |
| enq_addr | input | AW | Byte address of the new load |
| enq_ready | output | 1 | Queue can take a load this cycle |
| req_valid | output | 1 | Cache request present |
| req_idx | output | log2(DEPTH) | Entry that owns the request |
| req_addr | output | AW | 16-byte aligned request address |
| fill_valid | input | 1 | Fill data present |
| fill_idx | input | log2(DEPTH) | Owning entry of the fill |
| fill_data | input | 128 | Returned 16-byte sub-block |
| ret_valid | output | 1 | A load retires |
| ret_addr | output | AW | Address of the retiring load |
| ret_data | output | 64 | 8-byte word of the retiring load |

## Verification
The bound checker watches the request port on every cycle. It checks the half-rate spacing, the alignment of request addresses, that no owner is requested twice in a row, and that occupancy stays in range. The bench scenarios are the only way to show the behaviours that need a history of loads: merging, the single request per sub-block, program-order retirement behind an outstanding miss with fills returned out of order, word selection by bit 3, the retire-and-enter race, and the full-queue stall.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
  localparam int SUB_LSB = 4;    // sub-block is 16 bytes
  localparam int LINE_W  = 128;
  localparam int WORD_W  = 64;
endpackage

// File: rtl/lmb_match.sv
// Finds the owning entry (non-merged, valid, not leaving) for a probe tag.
module lmb_match #(
  parameter int DEPTH = 8,
  parameter int TW    = 28,
  parameter int IDXW  = 3
) (
  input  logic [DEPTH-1:0] owner_vld,
  input  logic [TW-1:0]    tag [DEPTH],
  input  logic [TW-1:0]    probe,
  output logic             hit,
  output logic [IDXW-1:0]  hit_idx
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = owner_vld[i] && (tag[i] == probe);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/lmb_pick.sv
// Oldest-first selection starting at the head pointer.
module lmb_pick #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [IDXW-1:0]  head,
  output logic             found,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int p;
      p = int'(head) + k;
      if (p >= DEPTH) p = p - DEPTH;
      if (cand[p]) begin
        found = 1'b1;
        idx   = IDXW'(p);
      end
    end
  end
endmodule

// File: rtl/lmb_issue.sv
// Request port: picks the oldest unrequested owner, applies the rate limit.
module lmb_issue #(
  parameter int DEPTH = 8,
  parameter int TW    = 28,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_rate,
  input  logic [DEPTH-1:0] cand,
  input  logic [IDXW-1:0]  head,
  input  logic [TW-1:0]    tag [DEPTH],
  output logic             fire,
  output logic [IDXW-1:0]  fire_idx,
  output logic             req_valid,
  output logic [IDXW-1:0]  req_idx,
  output logic [TW+3:0]    req_addr
);
  logic found;
  logic allow;

  lmb_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
    .cand  (cand),
    .head  (head),
    .found (found),
    .idx   (fire_idx)
  );

  assign allow = !half_rate || !req_valid;
  assign fire  = found && allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_idx   <= '0;
      req_addr  <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_idx  <= fire_idx;
        req_addr <= {tag[fire_idx], 4'b0000};
      end
    end
  end
endmodule

// File: rtl/load_merge_buf.sv
module load_merge_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        half_rate,
  input  logic                        enq_valid,
  input  logic [AW-1:0]               enq_addr,
  output logic                        enq_ready,
  output logic                        req_valid,
  output logic [$clog2(DEPTH)-1:0]    req_idx,
  output logic [AW-1:0]               req_addr,
  input  logic                        fill_valid,
  input  logic [$clog2(DEPTH)-1:0]    fill_idx,
  input  logic [lmb_pkg::LINE_W-1:0]  fill_data,
  output logic                        ret_valid,
  output logic [AW-1:0]               ret_addr,
  output logic [lmb_pkg::WORD_W-1:0]  ret_data
);
  import lmb_pkg::*;
  localparam int IDXW = $clog2(DEPTH);
  localparam int TW   = AW - SUB_LSB;
  localparam logic [IDXW:0] FULL_CNT = (IDXW + 1)'(DEPTH);

  logic [DEPTH-1:0]  v_q, mg_q, rq_q, rdy_q;
  logic [AW-1:0]     addr_q [DEPTH];
  logic [IDXW-1:0]   own_q  [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [TW-1:0]     tag    [DEPTH];
  logic [IDXW-1:0]   head_q, tail_q;
  logic [IDXW:0]     cnt_q;

  logic             retire, push, hit, fill_now, fire;
  logic [IDXW-1:0]  hit_own, fire_idx;
  logic [DEPTH-1:0] kill, owner_vld, cand;

  function automatic logic [IDXW-1:0] nxt(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    assign tag[i] = addr_q[i][AW-1:SUB_LSB];
  end

  assign retire    = v_q[head_q] && rdy_q[head_q];
  assign enq_ready = (cnt_q != FULL_CNT);
  assign push      = enq_valid && enq_ready;
  assign kill      = retire ? (DEPTH'(1) << head_q) : '0;
  assign owner_vld = v_q & ~mg_q & ~kill;
  assign cand      = v_q & ~mg_q & ~rq_q;
  assign fill_now  = fill_valid && (fill_idx == hit_own);

  lmb_match #(.DEPTH(DEPTH), .TW(TW), .IDXW(IDXW)) u_match (
    .owner_vld (owner_vld),
    .tag       (tag),
    .probe     (enq_addr[AW-1:SUB_LSB]),
    .hit       (hit),
    .hit_idx   (hit_own)
  );

  lmb_issue #(.DEPTH(DEPTH), .TW(TW), .IDXW(IDXW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .half_rate (half_rate),
    .cand      (cand),
    .head      (head_q),
    .tag       (tag),
    .fire      (fire),
    .fire_idx  (fire_idx),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_addr  (req_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= '0;
      mg_q      <= '0;
      rq_q      <= '0;
      rdy_q     <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
      ret_valid <= 1'b0;
    end else begin
      ret_valid <= retire;
      if (retire) begin
        ret_addr     <= addr_q[head_q];
        ret_data     <= addr_q[head_q][3] ? line_q[head_q][LINE_W-1:WORD_W]
                                          : line_q[head_q][WORD_W-1:0];
        v_q[head_q]  <= 1'b0;
        head_q       <= nxt(head_q);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_valid && v_q[i] && !rdy_q[i] &&
            (mg_q[i] ? (own_q[i] == fill_idx) : (IDXW'(i) == fill_idx))) begin
          rdy_q[i]  <= 1'b1;
          line_q[i] <= fill_data;
        end
      end
      if (fire) rq_q[fire_idx] <= 1'b1;
      if (push) begin
        v_q[tail_q]    <= 1'b1;
        addr_q[tail_q] <= enq_addr;
        mg_q[tail_q]   <= hit;
        rq_q[tail_q]   <= 1'b0;
        own_q[tail_q]  <= hit_own;
        rdy_q[tail_q]  <= hit && (rdy_q[hit_own] || fill_now);
        line_q[tail_q] <= fill_now ? fill_data : line_q[hit_own];
        tail_q         <= nxt(tail_q);
      end
      cnt_q <= cnt_q + {{IDXW{1'b0}}, push} - {{IDXW{1'b0}}, retire};
    end
  end
endmodule

// File: rtl/lmb_checker.sv
module lmb_checker #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            half_rate,
  input logic            req_valid,
  input logic [IDXW-1:0] req_idx,
  input logic [3:0]      req_lo,
  input logic [IDXW:0]   cnt
);
  AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
    half_rate && req_valid |=> !req_valid); // R6
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_lo == 4'd0); // R3
  AST_NO_REPEAT_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid && $past(req_valid) |-> req_idx != $past(req_idx)); // R7
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= (IDXW + 1)'(DEPTH)); // R1
endmodule

bind load_merge_buf lmb_checker #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .half_rate (half_rate),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .req_lo    (req_addr[3:0]),
  .cnt       (cnt_q)
);

// File: tb/tb_load_merge_buf.sv
`timescale 1ns/1ps
module tb_load_merge_buf;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int IDXW  = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1, half_rate = 1'b0;
  logic enq_valid = 1'b0;
  logic [AW-1:0] enq_addr = '0;
  logic enq_ready, req_valid, ret_valid;
  logic [IDXW-1:0] req_idx;
  logic [AW-1:0] req_addr, ret_addr;
  logic fill_valid = 1'b0;
  logic [IDXW-1:0] fill_idx = '0;
  logic [127:0] fill_data = '0;
  logic [63:0] ret_data;

  load_merge_buf #(.DEPTH(DEPTH), .AW(AW)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, req_total = 0, ret_total = 0, b2b = 0;
  bit prev_req = 0, auto_fill = 0, manual_fill = 0, done = 0;
  logic [AW-1:0] manual_addr;
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] pend_addr[$];
  int pend_idx[$];
  logic [AW-1:0] req_log[$];

  function automatic logic [63:0] word_of(input logic [AW-1:0] a);
    logic [AW-1:0] b;
    b = a & ~32'h7;
    return {b, ~b};
  endfunction

  function automatic logic [127:0] line_of(input logic [AW-1:0] base);
    return {word_of(base + 32'd8), word_of(base)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // One cycle: sample outputs at the falling edge, then drive fills.
  task automatic step();
    logic [AW-1:0] e;
    int sel;
    @(negedge clk);
    if (ret_valid) begin
      ret_total++;
      if (exp_q.size() == 0) chk(0, "R5", "unexpected retire", ret_addr, 0);
      else begin
        e = exp_q.pop_front();
        chk(ret_addr == e, "R5", "ret_addr order", ret_addr, e);
        chk(ret_data == word_of(e), "R5", "ret_data word", ret_data, word_of(e));
      end
    end
    if (req_valid) begin
      bit dup = 0;
      foreach (pend_addr[k]) if (pend_addr[k] == req_addr) dup = 1;
      chk(!dup, "R4", "second request for unfilled sub-block", req_addr, 0);
      chk(req_addr[3:0] == 4'd0, "R3", "request alignment", req_addr[3:0], 0);
      if (half_rate) chk(!prev_req, "R6", "back-to-back in half rate", 1, 0);
      if (prev_req) b2b++;
      pend_addr.push_back(req_addr);
      pend_idx.push_back(int'(req_idx));
      req_log.push_back(req_addr);
      req_total++;
    end
    prev_req = req_valid;
    fill_valid = 1'b0;
    sel = -1;
    if (manual_fill) begin
      foreach (pend_addr[k]) if (sel < 0 && pend_addr[k] == manual_addr) sel = k;
      manual_fill = 0;
    end else if (auto_fill && pend_addr.size() > 0 && ($urandom % 3) == 0) begin
      sel = int'($urandom % pend_addr.size());
    end
    if (sel >= 0) begin
      fill_valid = 1'b1;
      fill_idx   = IDXW'(pend_idx[sel]);
      fill_data  = line_of(pend_addr[sel]);
      pend_addr.delete(sel);
      pend_idx.delete(sel);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic enq(input logic [AW-1:0] a);
    while (!enq_ready) step();
    enq_valid = 1'b1;
    enq_addr  = a;
    exp_q.push_back(a);
    step();
    enq_valid = 1'b0;
  endtask

  task automatic fill_sub(input logic [AW-1:0] a);
    manual_addr = a & ~32'hF;
    manual_fill = 1;
    step();
  endtask

  task automatic drain();
    auto_fill = 1;
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || pend_addr.size() != 0); i++) step();
    steps(3);
    chk(exp_q.size() == 0, "R5", "all loads retired", exp_q.size(), 0);
    auto_fill = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int r0, t0, b0;
    void'($urandom(32'h0005_eed1));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step();
    // R1: reset state
    chk(enq_ready == 1'b1, "R1", "enq_ready after reset", enq_ready, 1);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
    chk(ret_valid == 1'b0, "R1", "ret_valid after reset", ret_valid, 0);

    // R2/R4/R5: merge, and younger loads wait behind an older miss
    r0 = req_total; t0 = ret_total;
    enq(32'h100); enq(32'h108); enq(32'h104); enq(32'h110);
    steps(5);
    chk(req_total - r0 == 2, "R4", "requests for 2 sub-blocks", req_total - r0, 2);
    fill_sub(32'h110);
    steps(4);
    chk(ret_total == t0, "R5", "no retire before oldest miss fills", ret_total - t0, 0);
    fill_sub(32'h100);
    steps(6);
    chk(ret_total - t0 == 4, "R5", "four retires in order", ret_total - t0, 4);

    // R2: bits 3..0 ignored, bit 4 and up compared
    r0 = req_total;
    enq(32'h200); enq(32'h20F); enq(32'h210); enq(32'h1F8);
    steps(5);
    chk(req_total - r0 == 3, "R2", "16-byte granularity", req_total - r0, 3);
    drain();

    // R8: owner retires in the cycle the matching load enters
    r0 = req_total;
    enq(32'h300);
    steps(3);
    fill_sub(32'h300);
    step();
    enq(32'h308);
    steps(4);
    chk(req_total - r0 == 2, "R8", "race load becomes owner", req_total - r0, 2);
    drain();

    // R4: merge onto an owner whose fill already came back
    r0 = req_total;
    enq(32'h400); enq(32'h500);
    steps(4);
    fill_sub(32'h500);
    steps(2);
    enq(32'h508);
    steps(4);
    chk(req_total - r0 == 2, "R4", "merge onto filled owner", req_total - r0, 2);
    fill_sub(32'h400);
    steps(6);
    chk(exp_q.size() == 0, "R4", "filled merge retires", exp_q.size(), 0);

    // R1: full queue stalls and ignores enq_valid
    r0 = req_total;
    for (int i = 0; i < DEPTH; i++) enq(32'h1000 + 32'(16 * i));
    step();
    chk(enq_ready == 1'b0, "R1", "enq_ready low when full", enq_ready, 0);
    enq_valid = 1'b1; enq_addr = 32'h9990;
    steps(3);
    chk(enq_ready == 1'b0, "R1", "still full", enq_ready, 0);
    enq_valid = 1'b0;
    drain();
    chk(req_total - r0 == DEPTH, "R1", "ignored load made no request", req_total - r0, DEPTH);

    // R6: half rate spacing
    half_rate = 1'b1;
    b0 = b2b; r0 = req_total;
    for (int i = 0; i < 4; i++) enq(32'h2000 + 32'(16 * i));
    steps(10);
    chk(b2b == b0, "R6", "no consecutive requests", b2b - b0, 0);
    chk(req_total - r0 == 4, "R6", "all requests issued", req_total - r0, 4);
    drain();

    // R7: full rate back to back, program order
    half_rate = 1'b0;
    b0 = b2b;
    req_log.delete();
    for (int i = 0; i < 4; i++) enq(32'h3000 + 32'(16 * i));
    steps(4);
    chk(b2b - b0 >= 3, "R7", "back-to-back requests", b2b - b0, 3);
    chk(req_log.size() == 4, "R7", "one request per owner", req_log.size(), 4);
    foreach (req_log[k])
      chk(req_log[k] == 32'h3000 + 32'(16 * k), "R7", "request order",
          req_log[k], 32'h3000 + 32'(16 * k));
    drain();

    // Random: both rates, dense addresses for many merges
    for (int m = 0; m < 2; m++) begin
      half_rate = m[0];
      auto_fill = 1;
      for (int i = 0; i < 250; i++) begin
        enq(32'h4000 + 32'(($urandom % 48) * 4));
        steps(int'($urandom % 3));
      end
      drain();
    end
    summary();
  end
endmodule